// File: doc/BRIEF.md
# Hit Cluster Width Filter

This block sits between the per-strip discriminators of a strip-detector readout bank and the logic that pairs hits from two sensor layers. On each clock it takes one binary hit vector for a single sensor layer, with one bit per strip. It locates clusters, which are runs of adjacent set strips, and removes every cluster that is wider than a programmable limit. Narrower clusters pass untouched. Wide clusters are typically left by low-angle or noisy tracks, so removing them reduces the load on the correlation stage downstream.

The hit vector is extended on both sides by a few edge strips from the adjacent chips. A cluster that straddles a chip boundary is therefore measured over its whole length. Only this chip's own strips are ever driven out. The result is registered and appears one clock after the input, together with a valid strobe. The block is a pure two-stage datapath: combinational run measurement feeding one output register. It has no sequencing state, so no state machine is used.

Top module: `hit_cluster_filter`

## Requirements
- R1: While rst_n is low, hits_out is all zeros and valid_out is 0.
- R2: valid_out equals the valid_in value of the previous clock. When valid_in was 1, hits_out holds the filtered version of that cycle's hits_in.
- R3: When valid_in is 0, hits_out keeps its previous value on the next clock.
- R4: When max_width is 0, filtering is disabled and hits_out equals the hits_in of the previous valid cycle.
- R5: A cluster whose total width is at most max_width (1..7) appears in hits_out bit for bit.
- R6: A cluster whose total width exceeds a non-zero max_width is entirely absent from hits_out.
- R7: With max_width of 1 or more, a single set strip with both neighbours clear always passes.
- R8: The cluster width includes adjacent set strips from the neighbour inputs. The extended strip order is {nbr_hi, hits_in, nbr_lo}. nbr_lo bit NB-1 lies next to hits_in bit 0, and nbr_hi bit 0 lies next to hits_in bit NSTRIPS-1.
- R9: Neighbour hits never appear in hits_out. With hits_in all zeros, hits_out is all zeros whatever nbr_lo and nbr_hi hold.
- R10: Clusters separated by at least one clear strip are judged independently of each other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Hit sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| max_width | input | MW (3) | Maximum accepted cluster width; 0 disables filtering |
| valid_in | input | 1 | hits_in carries a new vector this cycle |
| hits_in | input | NSTRIPS (128) | Per-strip binary hits of this chip |
| nbr_lo | input | NB (7) | Edge hits of the lower neighbour chip; bit NB-1 adjoins strip 0 |
| nbr_hi | input | NB (7) | Edge hits of the upper neighbour chip; bit 0 adjoins strip NSTRIPS-1 |
| valid_out | output | 1 | hits_out was refreshed from a valid input |
| hits_out | output | NSTRIPS (128) | Filtered hit vector |

## Verification
The assertions assume that max_width and both neighbour vectors are stable within the cycle in which valid_in is high. They also assume that the neighbour inputs describe the same clock period as hits_in, because the block measures whatever is presented to it. The bench changes every input only on the falling clock edge and raises valid_in together with a complete vector, so every captured cycle is coherent. The boundary patterns are arranged so that the neighbour part of a cluster sits exactly against strip 0 or strip 127. The random patterns drive all three vectors from the same generator in the same cycle.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
    // Largest limit expressible in a field of the given width.
    function automatic int unsigned cwf_max_limit(input int unsigned mw);
        return (1 << mw) - 1;
    endfunction
    // Counter width holding any run beyond the largest limit.
    function automatic int unsigned cwf_count_width(input int unsigned mw);
        return mw + 1;
    endfunction
endpackage

// File: rtl/cwf_run_len.sv
// Saturating running count of consecutive set bits ending at each index,
// counted from index 0 upward. Only the top NOUT counts are exported.
module cwf_run_len #(
    parameter int unsigned M    = 135,
    parameter int unsigned NOUT = 128,
    parameter int unsigned CW   = 4
) (
    input  logic [M-1:0]       v,
    output logic [NOUT*CW-1:0] cnt
);
    localparam logic [CW-1:0] SAT = '1;
    localparam int unsigned   OFS = M - NOUT;

    logic [CW-1:0] chain [M];

    assign chain[0] = v[0] ? CW'(1) : '0;

    for (genvar i = 1; i < M; i++) begin : g_chain
        assign chain[i] = !v[i]              ? '0  :
                          (chain[i-1] == SAT) ? SAT :
                                                chain[i-1] + CW'(1);
    end

    for (genvar q = 0; q < NOUT; q++) begin : g_out
        assign cnt[q*CW +: CW] = chain[OFS + q];
    end
endmodule

// File: rtl/cwf_keep.sv
// Decides per chip strip whether its cluster survives the width limit.
module cwf_keep #(
    parameter int unsigned N  = 128,
    parameter int unsigned CW = 4,
    parameter int unsigned MW = 3
) (
    input  logic [N-1:0]    v,
    input  logic [N*CW-1:0] lcnt,
    input  logic [N*CW-1:0] rcnt,
    input  logic [MW-1:0]   max_width,
    output logic [N-1:0]    keep
);
    localparam int unsigned SW = CW + 1;

    for (genvar j = 0; j < N; j++) begin : g_strip
        logic [SW-1:0] width;
        // Both counts include strip j itself, so subtract one.
        assign width   = SW'(lcnt[j*CW +: CW]) + SW'(rcnt[j*CW +: CW]) - SW'(1);
        assign keep[j] = v[j] && ((max_width == '0) || (width <= SW'(max_width)));
    end
endmodule

// File: rtl/hit_cluster_filter.sv
module hit_cluster_filter
    import cwf_pkg::*;
#(
    parameter int unsigned NSTRIPS = 128,
    parameter int unsigned MW      = 3,
    localparam int unsigned NB     = cwf_max_limit(MW)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [MW-1:0]      max_width,
    input  logic               valid_in,
    input  logic [NSTRIPS-1:0] hits_in,
    input  logic [NB-1:0]      nbr_lo,
    input  logic [NB-1:0]      nbr_hi,
    output logic               valid_out,
    output logic [NSTRIPS-1:0] hits_out
);
    localparam int unsigned CW = cwf_count_width(MW);
    localparam int unsigned E  = NSTRIPS + 2 * NB;
    localparam int unsigned M  = NSTRIPS + NB;

    logic [E-1:0]          v_ext;
    logic [M-1:0]          v_rev;
    logic [NSTRIPS*CW-1:0] lcnt;
    logic [NSTRIPS*CW-1:0] rout;
    logic [NSTRIPS*CW-1:0] rcnt;
    logic [NSTRIPS-1:0]    hits_next;

    assign v_ext = {nbr_hi, hits_in, nbr_lo};

    // Reverse the upper part so one counter design measures runs downward.
    for (genvar k = 0; k < M; k++) begin : g_rev
        assign v_rev[k] = v_ext[E-1-k];
    end

    cwf_run_len #(.M(M), .NOUT(NSTRIPS), .CW(CW)) u_left (
        .v   (v_ext[M-1:0]),
        .cnt (lcnt)
    );

    cwf_run_len #(.M(M), .NOUT(NSTRIPS), .CW(CW)) u_right (
        .v   (v_rev),
        .cnt (rout)
    );

    for (genvar j = 0; j < NSTRIPS; j++) begin : g_rmap
        assign rcnt[j*CW +: CW] = rout[(NSTRIPS-1-j)*CW +: CW];
    end

    cwf_keep #(.N(NSTRIPS), .CW(CW), .MW(MW)) u_keep (
        .v         (hits_in),
        .lcnt      (lcnt),
        .rcnt      (rcnt),
        .max_width (max_width),
        .keep      (hits_next)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            hits_out  <= '0;
        end else begin
            valid_out <= valid_in;
            if (valid_in) begin
                hits_out <= hits_next;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);

    // R2
    valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> $stable(hits_out));

    // R4
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && max_width == '0) |=> (hits_out == $past(hits_in)));

    // R9
    no_new_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> ((hits_out & ~$past(hits_in)) == '0));

    for (genvar j = 1; j < NSTRIPS - 1; j++) begin : g_iso
        // R7
        isolated_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_in && max_width != '0 && hits_in[j] && !hits_in[j-1] && !hits_in[j+1])
            |=> hits_out[j]);
    end
endmodule

// File: tb/hit_cluster_filter_tb_top.sv
`timescale 1ns/1ps
module hit_cluster_filter_tb_top;
    localparam int N  = 128;
    localparam int MW = 3;
    localparam int NB = 7;
    localparam int E  = N + 2 * NB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [MW-1:0] max_width = '0;
    logic          valid_in = 1'b0;
    logic [N-1:0]  hits_in = '0;
    logic [NB-1:0] nbr_lo = '0;
    logic [NB-1:0] nbr_hi = '0;
    logic          valid_out;
    logic [N-1:0]  hits_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hit_cluster_filter #(.NSTRIPS(N), .MW(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .max_width(max_width), .valid_in(valid_in),
        .hits_in(hits_in), .nbr_lo(nbr_lo), .nbr_hi(nbr_hi),
        .valid_out(valid_out), .hits_out(hits_out)
    );

    typedef struct packed {
        logic [2:0] mx;
        logic [7:0] start;
        logic [7:0] len;
        logic [3:0] lo;
        logic [3:0] hi;
        logic       keep;
    } vec_t;

    // max, first strip, length, lower/upper neighbour fill, expected survival
    localparam vec_t TBL [16] = '{
        '{3'd3,  8'd10,  8'd3, 4'd0, 4'd0, 1'b1},   // R5
        '{3'd3,  8'd10,  8'd4, 4'd0, 4'd0, 1'b0},   // R6
        '{3'd1,  8'd50,  8'd1, 4'd0, 4'd0, 1'b1},   // R7
        '{3'd1,  8'd50,  8'd2, 4'd0, 4'd0, 1'b0},   // R6
        '{3'd7,  8'd20,  8'd7, 4'd0, 4'd0, 1'b1},   // R5
        '{3'd7,  8'd20,  8'd8, 4'd0, 4'd0, 1'b0},   // R6
        '{3'd4,  8'd0,   8'd2, 4'd2, 4'd0, 1'b1},   // R8
        '{3'd4,  8'd0,   8'd2, 4'd3, 4'd0, 1'b0},   // R8
        '{3'd4,  8'd126, 8'd2, 4'd0, 4'd2, 1'b1},   // R8
        '{3'd4,  8'd126, 8'd2, 4'd0, 4'd3, 1'b0},   // R8
        '{3'd2,  8'd0,   8'd1, 4'd0, 4'd0, 1'b1},   // R7
        '{3'd5,  8'd100, 8'd9, 4'd0, 4'd0, 1'b0},   // R6
        '{3'd7,  8'd0,   8'd1, 4'd7, 4'd0, 1'b0},   // R8
        '{3'd0,  8'd30,  8'd20, 4'd0, 4'd0, 1'b1},  // R4
        '{3'd6,  8'd127, 8'd1, 4'd0, 4'd6, 1'b0},   // R8
        '{3'd2,  8'd64,  8'd2, 4'd0, 4'd0, 1'b1}    // R5
    };

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference: scan runs of the extended vector, clear runs over the limit.
    function automatic logic [N-1:0] model(input logic [E-1:0] v, input int mx);
        logic [E-1:0] o;
        int i;
        o = v;
        i = 0;
        while (i < E) begin
            if (v[i]) begin
                int s;
                s = i;
                while (i < E && v[i]) i++;
                if (mx != 0 && (i - s) > mx) begin
                    for (int k = s; k < i; k++) o[k] = 1'b0;
                end
            end else begin
                i++;
            end
        end
        return o[NB +: N];
    endfunction

    task automatic drive(input int mx, input logic [N-1:0] h,
                         input logic [NB-1:0] lo, input logic [NB-1:0] hi, input logic vin);
        @(negedge clk);
        max_width = MW'(mx);
        hits_in   = h;
        nbr_lo    = lo;
        nbr_hi    = hi;
        valid_in  = vin;
    endtask

    logic [31:0] rng = 32'h1234_5678;
    function automatic logic [31:0] next_rng(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    initial begin
        logic [N-1:0]  h;
        logic [N-1:0]  exp;
        logic [NB-1:0] lo;
        logic [NB-1:0] hi;

        // R1: outputs cleared while reset is held
        hits_in  = '1;
        valid_in = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 hits_out in reset", hits_out, '0);
        check("R1 valid_out in reset", N'(valid_out), '0);
        valid_in = 1'b0;
        hits_in  = '0;
        rst_n    = 1'b1;

        // Table walk (R4 R5 R6 R7 R8)
        for (int t = 0; t < 16; t++) begin
            h = '0;
            for (int k = 0; k < int'(TBL[t].len); k++) begin
                if (int'(TBL[t].start) + k < N) h[int'(TBL[t].start) + k] = 1'b1;
            end
            lo = NB'(((1 << TBL[t].lo) - 1) << (NB - int'(TBL[t].lo)));
            hi = NB'((1 << TBL[t].hi) - 1);
            drive(int'(TBL[t].mx), h, lo, hi, 1'b1);
            @(negedge clk);
            check($sformatf("R5/R6 table entry %0d", t), hits_out, TBL[t].keep ? h : '0);
            check($sformatf("R2 valid entry %0d", t), N'(valid_out), N'(1));
        end

        // R9: neighbour hits alone produce nothing
        drive(3, '0, '1, '1, 1'b1);
        @(negedge clk);
        check("R9 neighbour-only", hits_out, '0);

        // R10: clusters separated by one clear strip judged independently
        h = '0;
        h[6:5] = 2'b11;
        h[11:8] = 4'b1111;
        h[13] = 1'b1;
        exp = '0;
        exp[6:5] = 2'b11;
        exp[13] = 1'b1;
        drive(2, h, '0, '0, 1'b1);
        @(negedge clk);
        check("R10 separate clusters", hits_out, exp);

        // R3 and R2: hold with valid_in low, valid_out drops
        drive(0, ~h, '0, '0, 1'b0);
        @(negedge clk);
        check("R3 hold on invalid", hits_out, exp);
        check("R2 valid_out drops", N'(valid_out), '0);
        @(negedge clk);
        check("R3 hold second cycle", hits_out, exp);

        // Random patterns against the reference (R2 R5 R6 R8)
        for (int t = 0; t < 60; t++) begin
            logic [N-1:0] a;
            logic [N-1:0] b;
            for (int w = 0; w < 4; w++) begin
                rng = next_rng(rng);
                a[w*32 +: 32] = rng;
                rng = next_rng(rng);
                b[w*32 +: 32] = rng;
            end
            h = (t % 3 == 0) ? (a | b) : (a & b);
            rng = next_rng(rng);
            lo = rng[6:0];
            hi = rng[14:8];
            drive(t % 8, h, lo, hi, 1'b1);
            @(negedge clk);
            check($sformatf("R6 random %0d max %0d", t, t % 8), hits_out,
                  model({hi, h, lo}, t % 8));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule